// File: doc/BRIEF.md
# Memory-Map Chip-Select Decoder

This block turns the 16-bit address of an 8-bit processor into active-low chip selects for a fixed memory map. The lower 32K goes to a single RAM device. The upper half is split two ways. Three 8K regions start at $A000, $C000 and $E000. Eight 1K peripheral windows fill $8000-$9FFF. The select logic is purely combinational and adds no cycles of latency.

Internally the block is built from two cascaded 3-to-8 decoder stages. Each stage has one active-high enable and two active-low enables. Address bits 13 and 14 play two roles: they are the select inputs of the coarse stage and the active-low enables of the fine stage. This shared use is what keeps the two granularities from overlapping.

A build parameter merges the two top 8K regions into one 16K ROM select. A qualify input gates every select, so a clock phase or a bus-valid strobe can hide address-settling glitches from the devices. Tie this input high when no gating is wanted.

Top module: `memmap_cs_decoder`

## Requirements
- R1: `ram_cs_no` is low for every address in $0000-$7FFF and high for every address in $8000-$FFFF, while `qual_i` is high.
- R2: In the default build (ROM_16K=0) the three region selects map as follows: `bank_a_cs_no` is low exactly for $A000-$BFFF, `rom_lo_cs_no` exactly for $C000-$DFFF, and `rom_hi_cs_no` exactly for $E000-$FFFF. Addresses in $8000-$9FFF assert none of these three.
- R3: `io_cs_no[n]` (n = 0..7) is low exactly for $8000 + n*$0400 through $8000 + n*$0400 + $03FF. The window index n is address bits 12:10, with bit 12 the most significant, so $8000 gives n=0 and $9FFF gives n=7.
- R4: All of `io_cs_no` stays high for every address below $8000 and for every address at or above $A000.
- R5: Each decoder stage drives all of its outputs high when it is disabled. When it is enabled it drives exactly one output low.
- R6: With ROM_16K=1, `rom_lo_cs_no` is low for the whole of $C000-$FFFF regardless of address bit 13, and `rom_hi_cs_no` stays high for every address.
- R7: For every one of the 65536 addresses, at most one of the twelve selects is low.
- R8: While `qual_i` is high, every address asserts exactly one select, in either ROM_16K setting.
- R9: While `qual_i` is low, all twelve selects are high for every address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 16 | Processor address bus |
| qual_i | input | 1 | Select qualifier; high lets selects through, low forces all high |
| ram_cs_no | output | 1 | Active-low RAM select, $0000-$7FFF |
| bank_a_cs_no | output | 1 | Active-low select, $A000-$BFFF |
| rom_lo_cs_no | output | 1 | Active-low ROM select, $C000-$DFFF (or $C000-$FFFF with ROM_16K=1) |
| rom_hi_cs_no | output | 1 | Active-low ROM select, $E000-$FFFF; held high with ROM_16K=1 |
| io_cs_no | output | 8 | Active-low 1K peripheral window selects, $8000-$9FFF |

## Verification
Two copies of the block run side by side, one per ROM_16K setting. Both are swept through all 65536 addresses with the qualifier high, and each result is compared with a range-based model built from address intervals rather than bit slices. This exposes a swapped select bit, a wrong window order and a missing enable term, and it also confirms that exactly one select is low at every address. Directed probes sit on the region edges ($7FFF/$8000, $9FFF/$A000, $BFFF/$C000, $DFFF/$E000, and every 1K boundary) to catch off-by-one decoding. A second sweep with the qualifier low, plus fast qualifier toggles at a fixed address, shows that the gate masks every select.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned STAGE_OUT = 1 << SEL_W;
  // address bit positions that carry the map structure
  localparam int unsigned HALF_BIT  = 15;
  localparam int unsigned UP_LO_BIT = 13;
  localparam int unsigned UP_HI_BIT = 14;
  localparam int unsigned IO_LO_BIT = 10;
  // coarse-stage output indices in use
  localparam int unsigned UP_BANK_A = 2;
  localparam int unsigned UP_ROM_LO = 4;
  localparam int unsigned UP_ROM_HI = 6;
  localparam int unsigned CS_W      = 4 + STAGE_OUT;
endpackage

// File: rtl/cs_stage_dec.sv
module cs_stage_dec #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned OUT_N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  input  logic             en_a_ni,
  input  logic             en_b_ni,
  output logic [OUT_N-1:0] y_no
);
  logic en;
  assign en = en_i & ~en_a_ni & ~en_b_ni;

  always_comb begin
    y_no = '1;
    if (en) y_no[sel_i] = 1'b0;
  end

  always_comb begin
    if (!$isunknown({sel_i, en_i, en_a_ni, en_b_ni})) begin
      if (en) begin
        p_one_low_r5: assert ($countones(~y_no) == 1)
          else $error("stage enabled without a single low output");
      end else begin
        p_all_high_r5: assert (&y_no)
          else $error("stage disabled but an output is low");
      end
    end
  end
endmodule

// File: rtl/cs_gate.sv
module cs_gate #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] cs_ni,
  input  logic         qual_i,
  output logic [W-1:0] cs_no
);
  assign cs_no = cs_ni | {W{~qual_i}};

  always_comb begin
    if (!$isunknown(qual_i) && !qual_i) begin
      p_gate_high_r9: assert (&cs_no)
        else $error("select low while qualifier is low");
    end
  end
endmodule

// File: rtl/memmap_cs_decoder.sv
module memmap_cs_decoder
  import memmap_pkg::*;
#(
  parameter bit ROM_16K = 1'b0
) (
  input  logic [15:0] addr_i,
  input  logic        qual_i,
  output logic        ram_cs_no,
  output logic        bank_a_cs_no,
  output logic        rom_lo_cs_no,
  output logic        rom_hi_cs_no,
  output logic [7:0]  io_cs_no
);
  logic                 a15, a14, a13;
  logic [SEL_W-1:0]     up_sel;
  logic [STAGE_OUT-1:0] up_y_n;
  logic [STAGE_OUT-1:0] io_y_n;
  logic [CS_W-1:0]      raw_n;
  logic [CS_W-1:0]      cs_n;

  assign a15 = addr_i[HALF_BIT];
  assign a14 = addr_i[UP_HI_BIT];
  assign a13 = addr_i[UP_LO_BIT];

  // bit 0 of the coarse select is tied low: only even outputs ever fire
  generate
    if (ROM_16K) begin : g_rom16
      assign up_sel = {a14, a13 & ~a14, 1'b0};
    end else begin : g_rom8
      assign up_sel = {a14, a13, 1'b0};
    end
  endgenerate

  cs_stage_dec #(.SEL_W(SEL_W)) u_up_stage (
    .sel_i   (up_sel),
    .en_i    (a15),
    .en_a_ni (1'b0),
    .en_b_ni (1'b0),
    .y_no    (up_y_n)
  );

  cs_stage_dec #(.SEL_W(SEL_W)) u_io_stage (
    .sel_i   (addr_i[IO_LO_BIT +: SEL_W]),
    .en_i    (a15),
    .en_a_ni (a13),
    .en_b_ni (a14),
    .y_no    (io_y_n)
  );

  assign raw_n = {io_y_n, up_y_n[UP_ROM_HI], up_y_n[UP_ROM_LO],
                  up_y_n[UP_BANK_A], a15};

  cs_gate #(.W(CS_W)) u_gate (
    .cs_ni  (raw_n),
    .qual_i (qual_i),
    .cs_no  (cs_n)
  );

  assign ram_cs_no    = cs_n[0];
  assign bank_a_cs_no = cs_n[1];
  assign rom_lo_cs_no = cs_n[2];
  assign rom_hi_cs_no = cs_n[3];
  assign io_cs_no     = cs_n[CS_W-1:4];

  logic unused_bits;
  assign unused_bits = ^{addr_i[IO_LO_BIT-1:0], up_y_n[0], up_y_n[1],
                         up_y_n[3], up_y_n[5], up_y_n[7]};

  always_comb begin
    if (!$isunknown({addr_i, qual_i})) begin
      p_at_most_one_r7: assert ($countones(~cs_n) <= 1)
        else $error("more than one select low");
      p_odd_high_r2: assert (up_y_n[1] & up_y_n[3] & up_y_n[5] & up_y_n[7])
        else $error("odd coarse output low");
      p_io_range_r4: assert (&io_cs_no || (a15 && !a14 && !a13))
        else $error("io window outside $8000-$9FFF");
      p_ram_half_r1: assert (ram_cs_no || !a15)
        else $error("ram select in upper half");
      if (ROM_16K) begin
        p_hi_idle_r6: assert (rom_hi_cs_no)
          else $error("top select low in 16K mode");
      end
      if (qual_i) begin
        p_one_sel_r8: assert ($countones(~cs_n) == 1)
          else $error("address without exactly one select");
      end
    end
  end
endmodule

// File: tb/memmap_cs_decoder_tb.sv
`timescale 1ns/1ps
module memmap_cs_decoder_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] addr;
  logic        qual;
  logic        ram8, ba8, rl8, rh8, ram16, ba16, rl16, rh16;
  logic [7:0]  io8, io16;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  memmap_cs_decoder #(.ROM_16K(1'b0)) u_dut (
    .addr_i(addr), .qual_i(qual), .ram_cs_no(ram8), .bank_a_cs_no(ba8),
    .rom_lo_cs_no(rl8), .rom_hi_cs_no(rh8), .io_cs_no(io8));

  memmap_cs_decoder #(.ROM_16K(1'b1)) u_dut_rom16 (
    .addr_i(addr), .qual_i(qual), .ram_cs_no(ram16), .bank_a_cs_no(ba16),
    .rom_lo_cs_no(rl16), .rom_hi_cs_no(rh16), .io_cs_no(io16));

  // {io[7:0], rom_hi, rom_lo, bank_a, ram}, active low
  function automatic logic [11:0] model(int a, bit r16, bit q);
    logic [11:0] v = '1;
    if (!q) return v;
    if (a < 'h8000) v[0] = 1'b0;
    else if (a < 'hA000) v[4 + (a - 'h8000) / 'h400] = 1'b0;
    else if (a < 'hC000) v[1] = 1'b0;
    else if (r16 || a < 'hE000) v[2] = 1'b0;
    else v[3] = 1'b0;
    return v;
  endfunction

  function automatic logic [11:0] got8();
    return {io8, rh8, rl8, ba8, ram8};
  endfunction
  function automatic logic [11:0] got16();
    return {io16, rh16, rl16, ba16, ram16};
  endfunction

  task automatic check(string req, logic [11:0] got, logic [11:0] exp, int a);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h got=%b exp=%b", req, a[15:0], got, exp);
    end
  endtask

  task automatic apply(int a, bit q);
    @(posedge clk);
    addr = a[15:0];
    qual = q;
    @(negedge clk);
  endtask

  task automatic t_reset();
    qual = 1'b0; addr = 16'h0000;
    repeat (3) @(negedge clk);
    check("R9 reset", got8(), 12'hFFF, 0);
    check("R9 reset", got16(), 12'hFFF, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_ram_edges();
    int pts[4] = '{'h0000, 'h7FFF, 'h8000, 'hFFFF};
    foreach (pts[i]) begin
      apply(pts[i], 1'b1);
      check("R1", got8(), model(pts[i], 1'b0, 1'b1), pts[i]);
    end
  endtask

  task automatic t_upper();
    int pts[8] = '{'h9FFF, 'hA000, 'hBFFF, 'hC000, 'hDFFF, 'hE000, 'hE020, 'hFFFF};
    foreach (pts[i]) begin
      apply(pts[i], 1'b1);
      check("R2", got8(), model(pts[i], 1'b0, 1'b1), pts[i]);
    end
  endtask

  task automatic t_io_windows();
    for (int n = 0; n < 8; n++) begin
      int base = 'h8000 + n * 'h400;
      apply(base, 1'b1);
      check("R3", got8(), model(base, 1'b0, 1'b1), base);
      apply(base + 'h3FF, 1'b1);
      check("R3", got8(), model(base + 'h3FF, 1'b0, 1'b1), base + 'h3FF);
    end
    apply('h7C00, 1'b1);
    check("R4 below", {io8, 4'hF}, 12'hFFF, 'h7C00);
    apply('hBC00, 1'b1);
    check("R4 above", {io8, 4'hF}, 12'hFFF, 'hBC00);
  endtask

  task automatic t_rom16();
    int pts[5] = '{'hC000, 'hDFFF, 'hE000, 'hFFFF, 'hA000};
    foreach (pts[i]) begin
      apply(pts[i], 1'b1);
      check("R6", got16(), model(pts[i], 1'b1, 1'b1), pts[i]);
    end
  endtask

  task automatic t_sweep();
    for (int a = 0; a < 65536; a++) begin
      apply(a, 1'b1);
      check("R5 R7 R8 rom8", got8(), model(a, 1'b0, 1'b1), a);
      check("R5 R7 R8 rom16", got16(), model(a, 1'b1, 1'b1), a);
    end
  endtask

  task automatic t_qual();
    for (int a = 0; a < 65536; a += 97) begin
      apply(a, 1'b0);
      check("R9 rom8", got8(), 12'hFFF, a);
      check("R9 rom16", got16(), 12'hFFF, a);
    end
    for (int k = 0; k < 6; k++) begin
      apply('h8400, k[0]);
      check("R9 toggle", got8(), model('h8400, 1'b0, k[0]), 'h8400);
    end
  endtask

  initial begin
    t_reset();
    t_ram_edges();
    t_upper();
    t_io_windows();
    t_rom16();
    t_sweep();
    t_qual();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule